// File: doc/BRIEF.md
# Dual-Lane 64-Bit Integer ALU

This block runs one integer operation on two independent 64-bit lanes at once. Each 128-bit source vector holds four 32-bit components, x, y, z and w. Component x sits at bits [31:0], y at [63:32], z at [95:64] and w at [127:96]. Lane 0 is the 64-bit value {y, x}, with x as the low half. Lane 1 is {z, w} read as {w, z}, with z as the low half. Both lanes use the same opcode. The result is written into a 128-bit destination vector with the same layout.

Requests arrive on a valid/ready stream and results leave on one. `in_ready` is high when the output register is empty, or when the consumer takes the current result in the same cycle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears in the output register one clock later. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold steady and no new request is accepted.

Top module: `alu64_dual`

## Requirements
- R1: Opcode 0 (add) writes the sum of the two lanes, modulo 2^64, for lane 0 and lane 1 independently. A carry out of lane 0 never reaches lane 1.
- R2: Opcode 1 (multiply) writes the low 64 bits of the product of each lane's two operands.
- R3: Opcode 2 (negate) writes the two's complement of each src0 lane. Opcode 3 (magnitude) writes the lane unchanged when it is non-negative and its negation otherwise. Both leave 0x8000000000000000 unchanged.
- R4: Opcode 4 (sign) writes a full 64-bit value per lane: all ones (-1) for a negative signed src0 lane, 1 for a positive one, and 0 for zero.
- R5: Opcodes 5/6 write the signed minimum/maximum of the two lanes. Opcodes 7/8 write the unsigned minimum/maximum. Each selects a whole 64-bit operand.
- R6: The compare opcodes are 9 (equal), 10 (not equal), 11 (unsigned less), 12 (unsigned greater-or-equal), 13 (signed less) and 14 (signed greater-or-equal). Each writes 0xFFFFFFFF when true and 0 when false. Lane 0's result goes to x and lane 1's to z, and y and w are written as 0.
- R7: Opcode 15 shifts left, 16 shifts right arithmetically (copying the sign) and 17 shifts right logically (filling zeros). The count for lane 0 is bits [5:0] of src1 component x, and the count for lane 1 is bits [5:0] of src1 component y. Higher count bits are ignored.
- R8: Opcodes 18 to 31 write an all-zero destination, and `out_valid` is still raised.
- R9: With `out_ready` high, `out_valid` is high in the cycle after each accepted request and low in the cycle after a cycle with no request.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `dst` and `out_valid` do not change.
- R11: A synchronous active-high `rst` clears `dst` to zero and `out_valid` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request this cycle |
| op | input | 5 | Operation code |
| src0 | input | 128 | First source vector, lanes {y,x} and {w,z} |
| src1 | input | 128 | Second source vector; also supplies the shift counts |
| out_valid | output | 1 | Result present in `dst` |
| out_ready | input | 1 | Consumer takes the result this cycle |
| dst | output | 128 | Destination vector |

## Verification
Every one of the 32 opcode values is run over the full cross product of a set of 64-bit corner operands: zero, one, two, -1, -2, the most negative and most positive values, and values with bits set only in the low or only in the high word. Lane 1 always gets a different operand pairing from lane 0. This shows whether a carry leaks across lanes, whether signed and unsigned ordering are confused, and whether the most negative value wraps. Some operands carry shift counts above 63 in their low word, and lane 0's second operand has a non-zero high word. Together these show whether a shift count is masked and taken from the right component. A stalled consumer and a reset in the middle of the stream check that the output holds and that the register clears.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_MUL  = 5'd1,
    OP_NEG  = 5'd2,
    OP_MAG  = 5'd3,
    OP_SGN  = 5'd4,
    OP_SMIN = 5'd5,
    OP_SMAX = 5'd6,
    OP_UMIN = 5'd7,
    OP_UMAX = 5'd8,
    OP_EQ   = 5'd9,
    OP_NE   = 5'd10,
    OP_ULT  = 5'd11,
    OP_UGE  = 5'd12,
    OP_SLT  = 5'd13,
    OP_SGE  = 5'd14,
    OP_SHL  = 5'd15,
    OP_SRA  = 5'd16,
    OP_SRL  = 5'd17
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_ARITH = 2'd1,
    SH_LOGIC = 2'd2
  } shift_kind_e;

  function automatic logic is_compare(alu_op_e o);
    return o inside {OP_EQ, OP_NE, OP_ULT, OP_UGE, OP_SLT, OP_SGE};
  endfunction
endpackage

// File: rtl/alu64_shift.sv
module alu64_shift
  import alu64_pkg::*;
#(
  parameter int WIDTH = 64,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [SHW-1:0]   amount,
  input  shift_kind_e      kind,
  output logic [WIDTH-1:0] result
);
  always_comb begin
    unique case (kind)
      SH_LEFT:  result = value << amount;
      SH_ARITH: result = WIDTH'($signed(value) >>> amount);
      SH_LOGIC: result = value >> amount;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/alu64_lane.sv
module alu64_lane
  import alu64_pkg::*;
#(
  parameter int COMP_W  = 32,
  localparam int LANE_W = 2 * COMP_W,
  localparam int SHW    = $clog2(LANE_W)
) (
  input  alu_op_e           op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [SHW-1:0]    amount,
  output logic [LANE_W-1:0] result
);
  localparam logic [LANE_W-1:0] TRUE_MASK = {{COMP_W{1'b0}}, {COMP_W{1'b1}}};
  localparam logic [LANE_W-1:0] ONE       = LANE_W'(1);

  logic              s_lt, u_lt, eq, a_neg;
  logic [LANE_W-1:0] neg_a, sh_res;
  shift_kind_e       kind;

  assign s_lt  = $signed(a) < $signed(b);
  assign u_lt  = a < b;
  assign eq    = a == b;
  assign a_neg = a[LANE_W-1];
  assign neg_a = '0 - a;

  always_comb begin
    unique case (op)
      OP_SRA:  kind = SH_ARITH;
      OP_SRL:  kind = SH_LOGIC;
      default: kind = SH_LEFT;
    endcase
  end

  alu64_shift #(.WIDTH(LANE_W)) u_shift (
    .value  (a),
    .amount (amount),
    .kind   (kind),
    .result (sh_res)
  );

  always_comb begin
    result = '0;
    case (op)
      OP_ADD:  result = a + b;
      OP_MUL:  result = a * b;
      OP_NEG:  result = neg_a;
      OP_MAG:  result = a_neg ? neg_a : a;
      OP_SGN:  result = a_neg ? '1 : ((a == '0) ? '0 : ONE);
      OP_SMIN: result = s_lt ? a : b;
      OP_SMAX: result = s_lt ? b : a;
      OP_UMIN: result = u_lt ? a : b;
      OP_UMAX: result = u_lt ? b : a;
      OP_EQ:   result = eq    ? TRUE_MASK : '0;
      OP_NE:   result = !eq   ? TRUE_MASK : '0;
      OP_ULT:  result = u_lt  ? TRUE_MASK : '0;
      OP_UGE:  result = !u_lt ? TRUE_MASK : '0;
      OP_SLT:  result = s_lt  ? TRUE_MASK : '0;
      OP_SGE:  result = !s_lt ? TRUE_MASK : '0;
      OP_SHL, OP_SRA, OP_SRL: result = sh_res;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/alu64_dual.sv
module alu64_dual
  import alu64_pkg::*;
#(
  parameter int COMP_W = 32,
  parameter int NCOMP  = 4,
  localparam int LANE_W = 2 * COMP_W,
  localparam int NLANE  = NCOMP / 2,
  localparam int VEC_W  = COMP_W * NCOMP,
  localparam int SHW    = $clog2(LANE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op,
  input  logic [VEC_W-1:0] src0,
  input  logic [VEC_W-1:0] src1,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] dst
);
  alu_op_e          op_e;
  logic [VEC_W-1:0] res_comb;
  logic [VEC_W-1:0] dst_q;
  logic             vld_q;
  logic             accept;

  assign op_e     = alu_op_e'(op);
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    alu64_lane #(.COMP_W(COMP_W)) u_lane (
      .op     (op_e),
      .a      (src0[g*LANE_W +: LANE_W]),
      .b      (src1[g*LANE_W +: LANE_W]),
      .amount (src1[g*COMP_W +: SHW]),
      .result (res_comb[g*LANE_W +: LANE_W])
    );

    // R6: a compare leaves the high component of the lane zero and the low one a full mask
    a_r6_compare_shape : assert property (@(posedge clk) disable iff (rst)
      (accept && is_compare(op_e)) |=>
        (dst[g*LANE_W+COMP_W +: COMP_W] == '0) &&
        ((dst[g*LANE_W +: COMP_W] == '0) || (dst[g*LANE_W +: COMP_W] == '1)));

    // R4: sign result is one of -1, 0, +1
    a_r4_sign_range : assert property (@(posedge clk) disable iff (rst)
      (accept && op_e == OP_SGN) |=>
        (dst[g*LANE_W +: LANE_W] == '0) || (dst[g*LANE_W +: LANE_W] == '1) ||
        (dst[g*LANE_W +: LANE_W] == LANE_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q <= '0;
      vld_q <= 1'b0;
    end else if (accept) begin
      dst_q <= res_comb;
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign dst       = dst_q;
  assign out_valid = vld_q;

  // R9: an accepted request shows up one clock later
  a_r9_one_cycle : assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R10: a stalled result holds
  a_r10_hold : assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst)));

  // R10: no request taken while stalled
  a_r10_no_take : assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/alu64_dual_bench.sv
module alu64_dual_bench;
  localparam int PERIOD = 10;
  localparam int NV = 12;

  logic         clk = 0;
  logic         rst;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [4:0]   op;
  logic [127:0] src0, src1, dst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  alu64_dual u_alu64_dual (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src0(src0), .src1(src1), .out_valid(out_valid),
    .out_ready(out_ready), .dst(dst)
  );

  function automatic logic [63:0] vals(int i);
    case (i % NV)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'h2;
      3:  return 64'hFFFF_FFFF_FFFF_FFFF;
      4:  return 64'hFFFF_FFFF_FFFF_FFFE;
      5:  return 64'h8000_0000_0000_0000;
      6:  return 64'h7FFF_FFFF_FFFF_FFFF;
      7:  return 64'h0000_0001_0000_0000;
      8:  return 64'h0000_0000_FFFF_FFFF;
      9:  return 64'h1234_5678_9ABC_DEF0;
      10: return 64'h0000_0003_0000_00C5;
      default: return 64'h0000_0027_0000_0041;
    endcase
  endfunction

  function automatic string tag(int o);
    if (o == 0) return "R1";
    if (o == 1) return "R2";
    if (o <= 3) return "R3";
    if (o == 4) return "R4";
    if (o <= 8) return "R5";
    if (o <= 14) return "R6";
    if (o <= 17) return "R7";
    return "R8";
  endfunction

  function automatic logic [63:0] mlane(int o, logic [63:0] a, logic [63:0] b, int cnt);
    logic signed [63:0] sa, sb;
    logic [63:0] t;
    sa = a; sb = b;
    t = 64'h0000_0000_FFFF_FFFF;
    case (o)
      0:  return a + b;
      1:  return a * b;
      2:  return 64'h0 - a;
      3:  return (sa < 0) ? 64'h0 - a : a;
      4:  return (sa < 0) ? 64'hFFFF_FFFF_FFFF_FFFF : ((a == 0) ? 64'h0 : 64'h1);
      5:  return (sa <= sb) ? a : b;
      6:  return (sa >= sb) ? a : b;
      7:  return (a <= b) ? a : b;
      8:  return (a >= b) ? a : b;
      9:  return (a == b) ? t : 64'h0;
      10: return (a != b) ? t : 64'h0;
      11: return (a < b) ? t : 64'h0;
      12: return (a >= b) ? t : 64'h0;
      13: return (sa < sb) ? t : 64'h0;
      14: return (sa >= sb) ? t : 64'h0;
      15: return a << cnt;
      16: return sa >>> cnt;
      17: return a >> cnt;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(int o, logic [63:0] a0, logic [63:0] b0,
                        logic [63:0] a1, logic [63:0] b1);
    logic [127:0] exp;
    exp = {mlane(o, a1, b1, int'(b0[63:32] & 32'h3F)),
           mlane(o, a0, b0, int'(b0[31:0] & 32'h3F))};
    @(negedge clk);
    op = o[4:0]; src0 = {a1, a0}; src1 = {b1, b0}; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    // R9 latency folded into each functional check
    check(out_valid && dst === exp, tag(o), {127'b0, out_valid} ^ dst, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; out_ready = 1; op = 0; src0 = 0; src1 = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!out_valid && dst == 0 && in_ready, "R11", dst, 128'h0);
    rst = 0;

    for (int o = 0; o < 32; o++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          run_op(o, vals(i), vals(j), vals(i + 3), vals(j + 7));

    // R9: idle cycle drops out_valid
    @(negedge clk);
    check(!out_valid, "R9", {127'b0, out_valid}, 128'h0);

    // R10: stall holds result and blocks input
    @(negedge clk);
    out_ready = 0; op = 0; src0 = {64'd5, 64'd7}; src1 = {64'd1, 64'd1}; in_valid = 1;
    @(negedge clk);
    check(out_valid && dst == {64'd6, 64'd8}, "R10", dst, {64'd6, 64'd8});
    src0 = {64'd100, 64'd200};
    check(!in_ready, "R10", {127'b0, in_ready}, 128'h0);
    repeat (2) @(negedge clk);
    check(out_valid && dst == {64'd6, 64'd8}, "R10", dst, {64'd6, 64'd8});
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid && dst == {64'd101, 64'd201}, "R10", dst, {64'd101, 64'd201});
    @(negedge clk);
    check(!out_valid, "R9", {127'b0, out_valid}, 128'h0);

    // R11: reset while a result is held
    out_ready = 0; op = 1; src0 = {64'd3, 64'd3}; src1 = {64'd3, 64'd3}; in_valid = 1;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check(!out_valid && dst == 0, "R11", dst, 128'h0);
    out_ready = 1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule